// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital front end of a converter with two 14-bit channels. A host shifts a command frame into it on a serial clock and data line while an active-low select/load line is held low. When that line returns high, the block decodes the frame's control byte and writes the frame's code into one or both channels.

The serial pins are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system clock domain. Each channel holds an input (staging) register and a DAC register. The two code outputs show only the DAC registers.

The most significant bit of the shift register appears on a serial output, so several devices can be chained on one data line. An asynchronous clear input drives both DAC registers to zero code at once.

Top module: `dual_dac_serial_if`

## Requirements
- R1: While `load_n` is low, each rising edge of `ser_clk` shifts `ser_data` into the least significant end of a 24-bit shift register, most significant bit of the frame first.
- R2: Rising edges of `ser_clk` while `load_n` is high do not move the shift register, so `ser_out` and the next decoded frame are unaffected.
- R3: On a rising edge of `load_n`, the last 24 bits shifted are decoded as follows: bits 23:20 are the command, bits 19:16 are the address, bits 15:2 are the 14-bit code, and bits 1:0 are ignored.
- R4: A frame longer than 24 bits (for example 32 bits) is accepted, and only its final 24 bits are used.
- R5: Command 0000 writes the code to the input register only. Command 0001 copies the input register to the DAC register. Command 0011 writes the code to both registers.
- R6: Address 0000 selects channel A, 0001 selects channel B, and 1111 selects both. A command executes exactly once per rising edge of `load_n`.
- R7: `ser_out` presents the bit that was shifted in 24 shift edges earlier, and it changes only on a shift.
- R8: `dac_clear` asynchronously forces both DAC registers to zero without waiting for a clock. Input registers keep their contents, so a later update command restores them to the outputs.
- R9: Command 1111 is a no-op. Any other command or address code not listed above also leaves every register unchanged.
- R10: After synchronous reset, both codes, both input registers and `ser_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data in |
| load_n | input | 1 | Active-low select; rising edge executes the frame |
| dac_clear | input | 1 | Asynchronous active-high clear of the DAC registers |
| ser_out | output | 1 | Shift-register output for chaining |
| code_a | output | 14 | Channel A DAC register |
| code_b | output | 14 | Channel B DAC register |

## Verification
Two situations are hard to reach from the ports. The first is a difference between a channel's input register and its DAC register. It is visible only after a staged load, a clear or an update, so the bench runs every one of the 256 control bytes in sequence against a running model of all four registers, with each frame carrying a distinct code. The second is the clear landing between clock edges. The bench raises it mid-period, checks the outputs before the next edge, and then issues an update to prove that the staged values survived.

// File: rtl/dac_if_pkg.sv
package dac_if_pkg;

    localparam int CODE_W  = 14;
    localparam int PAD_W   = 2;
    localparam int FIELD_W = 4;
    localparam int FRAME_W = 2 * FIELD_W + CODE_W + PAD_W;
    localparam int NUM_CH  = 2;

    typedef enum logic [FIELD_W-1:0] {
        CMD_STAGE    = 4'h0,
        CMD_COMMIT   = 4'h1,
        CMD_STAGE_GO = 4'h3,
        CMD_IDLE     = 4'hF
    } cmd_e;

    typedef enum logic [FIELD_W-1:0] {
        SEL_A    = 4'h0,
        SEL_B    = 4'h1,
        SEL_BOTH = 4'hF
    } sel_e;

    typedef struct packed {
        logic [FIELD_W-1:0] cmd;
        logic [FIELD_W-1:0] sel;
        logic [CODE_W-1:0]  code;
        logic [PAD_W-1:0]   pad;
    } frame_t;

    typedef struct packed {
        logic stage;
        logic commit;
    } action_t;

    function automatic action_t cmd_action(input logic [FIELD_W-1:0] c);
        action_t a;
        a = '0;
        case (c)
            CMD_STAGE:    a.stage  = 1'b1;
            CMD_COMMIT:   a.commit = 1'b1;
            CMD_STAGE_GO: begin a.stage = 1'b1; a.commit = 1'b1; end
            default:      a = '0;
        endcase
        return a;
    endfunction

    function automatic logic [NUM_CH-1:0] sel_mask(input logic [FIELD_W-1:0] s);
        logic [NUM_CH-1:0] m;
        case (s)
            SEL_A:    m = 2'b01;
            SEL_B:    m = 2'b10;
            SEL_BOTH: m = 2'b11;
            default:  m = 2'b00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dac_shift.sv
module dac_shift #(
    parameter int FRAME_W = 24
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] sreg
);
    always_ff @(posedge clk) begin
        if (rst)           sreg <= '0;
        else if (shift_en) sreg <= {sreg[FRAME_W-2:0], din};
    end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              stage,
    input  logic              commit,
    input  logic [CODE_W-1:0] new_code,
    output logic [CODE_W-1:0] code
);
    logic [CODE_W-1:0] staged;

    always_ff @(posedge clk) begin
        if (rst)        staged <= '0;
        else if (stage) staged <= new_code;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr)         code <= '0;
        else if (rst)    code <= '0;
        else if (commit) code <= stage ? new_code : staged;
    end
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
    import dac_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              load_n,
    input  logic              dac_clear,
    output logic              ser_out,
    output logic [CODE_W-1:0] code_a,
    output logic [CODE_W-1:0] code_b
);
    localparam logic [2:0] SYNC_RST = 3'b100;

    logic [2:0]         pins_s;
    logic               sck_s, sdi_s, cs_s;
    logic               sck_d, cs_d;
    logic               shift_en;
    logic               strobe;
    logic [FRAME_W-1:0] sreg;
    frame_t             frm;
    action_t            act;
    logic [NUM_CH-1:0]  mask;
    logic [CODE_W-1:0]  codes [NUM_CH];

    dac_sync #(.W(3), .STAGES(2), .RST_VAL(SYNC_RST)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({load_n, ser_data, ser_clk}),
        .q   (pins_s)
    );

    assign {cs_s, sdi_s, sck_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d  <= 1'b0;
            cs_d   <= 1'b1;
            strobe <= 1'b0;
        end else begin
            sck_d  <= sck_s;
            cs_d   <= cs_s;
            strobe <= cs_s & ~cs_d;
        end
    end

    assign shift_en = sck_s & ~sck_d & ~cs_s;

    dac_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .din      (sdi_s),
        .sreg     (sreg)
    );

    assign ser_out = sreg[FRAME_W-1];
    assign frm     = frame_t'(sreg);
    assign act     = cmd_action(frm.cmd);
    assign mask    = sel_mask(frm.sel);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dac_chan #(.CODE_W(CODE_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .clr      (dac_clear),
            .stage    (strobe & act.stage  & mask[ch]),
            .commit   (strobe & act.commit & mask[ch]),
            .new_code (frm.code),
            .code     (codes[ch])
        );
    end

    assign code_a = codes[0];
    assign code_b = codes[1];
endmodule

// File: rtl/dual_dac_serial_if_chk.sv
module dual_dac_serial_if_chk
    import dac_if_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               dac_clear,
    input logic               cs_s,
    input logic               shift_en,
    input logic               strobe,
    input logic [FRAME_W-1:0] sreg,
    input logic               ser_out,
    input logic [CODE_W-1:0]  code_a,
    input logic [CODE_W-1:0]  code_b
);
    // R2: no shifting while deselected
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> $stable(sreg));

    // R6: one execute pulse per load edge
    p_single_exec_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    // R7: chained output advances by one frame bit per shift
    p_chain_out_r7: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> ser_out == $past(sreg[FRAME_W-2]));

    // R8: clear holds both outputs at zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        dac_clear |-> (code_a == '0 && code_b == '0));

    // R9: outputs move only on an execute pulse
    p_hold_codes_r9: assert property (@(posedge clk) disable iff (rst || dac_clear)
        !strobe |=> ($stable(code_a) && $stable(code_b)));

    // R9: unknown command codes never move the outputs
    p_unknown_cmd_r9: assert property (@(posedge clk) disable iff (rst || dac_clear)
        (strobe && sreg[FRAME_W-1 -: 4] != 4'h1 && sreg[FRAME_W-1 -: 4] != 4'h3)
        |=> ($stable(code_a) && $stable(code_b)));
endmodule

bind dual_dac_serial_if dual_dac_serial_if_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .dac_clear (dac_clear),
    .cs_s      (cs_s),
    .shift_en  (shift_en),
    .strobe    (strobe),
    .sreg      (sreg),
    .ser_out   (ser_out),
    .code_a    (code_a),
    .code_b    (code_b)
);

// File: tb/dual_dac_serial_if_tb.sv
module dual_dac_serial_if_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF_BIT   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        load_n = 1'b1;
    logic        dac_clear = 1'b0;
    logic        ser_out;
    logic [13:0] code_a, code_b;

    int checks = 0;
    int errors = 0;

    logic [23:0] m_sreg = '0;
    logic [13:0] m_in_a = '0, m_in_b = '0, m_dac_a = '0, m_dac_b = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_dac_serial_if u_dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .load_n(load_n), .dac_clear(dac_clear), .ser_out(ser_out),
        .code_a(code_a), .code_b(code_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift n bits MSB first; R1/R7 checked after every shift.
    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = bits[i];
            idle(HALF_BIT);
            ser_clk = 1'b1;
            idle(HALF_BIT);
            m_sreg = {m_sreg[22:0], bits[i]};
            check("R7", {31'b0, ser_out}, {31'b0, m_sreg[23]});
            ser_clk = 1'b0;
        end
    endtask

    task automatic model_exec();
        logic [3:0]  c, s;
        logic [13:0] v;
        logic        sa, sb, st, cm;
        c = m_sreg[23:20]; s = m_sreg[19:16]; v = m_sreg[15:2];
        sa = (s == 4'h0) || (s == 4'hF);
        sb = (s == 4'h1) || (s == 4'hF);
        st = (c == 4'h0) || (c == 4'h3);
        cm = (c == 4'h1) || (c == 4'h3);
        if (sa && cm) m_dac_a = st ? v : m_in_a;
        if (sb && cm) m_dac_b = st ? v : m_in_b;
        if (sa && st) m_in_a = v;
        if (sb && st) m_in_b = v;
    endtask

    task automatic send(input logic [31:0] bits, input int n, input string req);
        load_n = 1'b0;
        idle(HALF_BIT);
        shift_bits(bits, n);
        idle(HALF_BIT);
        load_n = 1'b1;
        idle(8);
        model_exec();
        check(req, {18'b0, code_a}, {18'b0, m_dac_a});
        check(req, {18'b0, code_b}, {18'b0, m_dac_b});
    endtask

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        // R10: reset state
        check("R10", {18'b0, code_a}, 32'h0);
        check("R10", {18'b0, code_b}, 32'h0);
        check("R10", {31'b0, ser_out}, 32'h0);

        // R3 R5 R6 R9: sweep of every control byte; pad bits vary (R3)
        for (int ctl = 0; ctl < 256; ctl++) begin
            logic [13:0] v;
            v = 14'((ctl * 1237 + 91) & 16'h3FFF);
            send({8'h0, ctl[7:0], v, ctl[1:0] ^ 2'b10}, 24, "R5_R6_R9");
        end

        // R5: stage then commit on both channels
        send({8'h0, 8'h0F, 14'h2A5C, 2'b11}, 24, "R5");
        check("R5", {18'b0, code_a}, {18'b0, m_dac_a});
        send({8'h0, 8'h1F, 14'h0001, 2'b00}, 24, "R5");
        check("R5", {18'b0, code_a}, 32'h2A5C);

        // R4: 32-bit frame whose leading byte would be a valid command
        send({8'h3F, 8'h30, 14'h1234, 2'b01}, 32, "R4");
        check("R4", {18'b0, code_a}, 32'h1234);
        check("R4", {18'b0, code_b}, 32'h2A5C);

        // R2: clocks while deselected are ignored
        ser_data = 1'b1;
        for (int k = 0; k < 5; k++) begin
            idle(HALF_BIT); ser_clk = 1'b1; idle(HALF_BIT); ser_clk = 1'b0;
        end
        check("R2", {31'b0, ser_out}, {31'b0, m_sreg[23]});
        send({8'h0, 8'h31, 14'h3FFF, 2'b00}, 24, "R2");

        // R8: asynchronous clear mid-period, staged values survive
        send({8'h0, 8'h00, 14'h0777, 2'b00}, 24, "R8");
        @(negedge clk); #2;
        dac_clear = 1'b1;
        #1;
        check("R8", {18'b0, code_a}, 32'h0);
        check("R8", {18'b0, code_b}, 32'h0);
        m_dac_a = '0; m_dac_b = '0;
        idle(3);
        dac_clear = 1'b0;
        idle(2);
        check("R8", {18'b0, code_a}, 32'h0);
        send({8'h0, 8'h1F, 14'h0000, 2'b00}, 24, "R8");
        check("R8", {18'b0, code_a}, 32'h0777);
        check("R8", {18'b0, code_b}, 32'h3FFF);

        // R1: chained frame emerges on ser_out
        send({8'h0, 8'hFF, 14'h1555, 2'b10}, 24, "R1");
        send({8'h0, 8'hFF, 14'h2AAA, 2'b01}, 24, "R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule